// File: doc/BRIEF.md
# Cartridge Program and Pattern Bank Translator

This block sits between an 8-bit console's buses and the cartridge ROMs and performs bank switching. CPU writes into the upper half of the CPU map are decoded into eight bank registers and a nametable mirroring control. Two address translators use these registers. The first maps the CPU program window 0x8000–0xFFFF onto a program ROM address. The second maps the video-side pattern window 0x0000–0x1FFF onto a character ROM address.

The program window is four 8 KiB slots. The two lower slots are switchable and the two upper slots are pinned to the final two banks of the ROM. The pattern window has two 2 KiB slots in its lower half and four 1 KiB slots in its upper half. Bank numbers that exceed the ROM size wrap modulo the number of banks of that size. Bank counts are parameters.

A parameter picks one of two variants. In the base variant, the mirroring bit rides along with a write to bank register 0. In the extended variant, the mirroring bit has its own register in the top 8 KiB of the write space, and no write at or above 0xC000 can reach a bank register.

Top module: `cart_bank_xlat`

## Requirements
- R1: Synchronous active-high reset clears all eight bank registers, sets mirroring to vertical (`mirror_h`=0), and clears `cpu_wr_hit`, `prg_sel`, `chr_sel` and both ROM address outputs.
- R2: A write is decoded on `cpu_wr_addr & 0xF003`. The values 0x8000–0x8003 select bank registers 0–3 and 0xA000–0xA003 select bank registers 4–7, so aliases such as 0x8FFC (register 0) and 0xAFF3 (register 7) also reach a register.
- R3: Registers 0 and 1 store only data bits 5:0. Registers 2–7 store all 8 bits.
- R4: CPU reads at 0x8000–0x9FFF give 8 KiB bank `reg0` and reads at 0xA000–0xBFFF give 8 KiB bank `reg1`. The ROM address is bank*8192 + (address & 0x1FFF).
- R5: CPU reads at 0xC000–0xDFFF give bank PRG_BANKS8-2 and reads at 0xE000–0xFFFF give bank PRG_BANKS8-1, whatever the registers hold.
- R6: Video reads at 0x0000–0x07FF use 2 KiB bank `reg2` and reads at 0x0800–0x0FFF use 2 KiB bank `reg3`. The ROM address is bank*2048 + (address & 0x7FF).
- R7: Video reads at 0x1000–0x1FFF use four 1 KiB slots selected by address bits 11:10, taken from `reg4`..`reg7` in that order. The ROM address is bank*1024 + (address & 0x3FF).
- R8: In the base variant (EXT_MODE=0), a write to register 0 also sets `mirror_h` to data bit 6 (1 = horizontal, 0 = vertical).
- R9: In the extended variant (EXT_MODE=1), a write whose masked address is 0xE000 sets `mirror_h` to data bit 6. A register-0 write leaves mirroring unchanged, and no write with address ≥ 0xC000 alters a bank register.
- R10: Each bank number is taken modulo the count of banks of its size: PRG_BANKS8 for 8 KiB, CHR_BANKS1K/2 for 2 KiB, and CHR_BANKS1K for 1 KiB.
- R11: `cpu_wr_hit` is high for the one cycle after a write that reached a register or the mirroring control. A write to any other decoded address changes nothing and leaves `cpu_wr_hit` low.
- R12: The translated addresses are registered. The output in the cycle after an address is presented reflects the register contents before that edge, so a write affects reads presented from the following cycle onward.
- R13: `prg_sel` follows CPU address bit 15 and `chr_sel` flags video addresses below 0x2000, both one cycle later. While a select is low, its ROM address output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_wr_addr | input | 16 | CPU write address |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_wr_hit | output | 1 | Previous cycle's write was handled |
| cpu_rd_addr | input | 16 | CPU read address |
| prg_rom_addr | output | PRG_AW | Program ROM byte address |
| prg_sel | output | 1 | Program window selected |
| vid_addr | input | 14 | Video-side read address |
| chr_rom_addr | output | CHR_AW | Character ROM byte address |
| chr_sel | output | 1 | Pattern window selected |
| mirror_h | output | 1 | Mirroring: 1 horizontal, 0 vertical |

## Verification
The bench runs a base-variant instance with power-of-two bank counts and an extended-variant instance with counts of 12 and 40, so the modulo wrap is tested on divisors that a bit-slice cannot imitate. A design that truncated bank bits instead of wrapping would land bank 13 of 12 on the wrong page. The bench writes through masked aliases (0x8FFC, 0xAFF3) and near-misses (0x9000, 0xC002). A decoder that compared the full address would drop the aliases, and one with a loose mask would accept the near-misses. It also writes 0xE000 and register 0 with bit 6 set on both variants, which exposes a mirroring source wired to the wrong register. Finally, it writes a bank while reading that same window, which catches a translator that bypasses the register and shows the new bank one cycle early.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

  localparam int PRG_PAGE = 8192;
  localparam int CHR_PAGE2 = 2048;
  localparam int CHR_PAGE1 = 1024;

  typedef logic [7:0][7:0] bank_file_t;

  typedef enum logic {
    MIR_VERT = 1'b0,
    MIR_HORZ = 1'b1
  } mirror_e;

  function automatic int wrap_bank(input logic [7:0] value, input int count);
    if (count < 1) return 0;
    return int'(value) % count;
  endfunction

endpackage

// File: rtl/cbx_regfile.sv
module cbx_regfile
  import cbx_pkg::*;
#(
  parameter bit EXT_MODE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0] wr_data,
  output bank_file_t regs,
  output mirror_e    mirror,
  output logic       hit
);

  localparam logic [15:0] DEC_MASK   = 16'hF003;
  localparam bit          R0_MIRRORS = !EXT_MODE;

  logic [15:0] masked;
  logic        bank_match;
  logic [2:0]  idx;
  logic [7:0]  keep;
  logic        upper_zone;
  logic        mir_match;
  logic        bank_wr;

  assign masked = wr_addr & DEC_MASK;

  always_comb begin
    bank_match = (masked[15:12] == 4'h8) || (masked[15:12] == 4'hA);
    idx        = {masked[13], masked[1:0]};
    keep       = (idx < 3'd2) ? 8'h3F : 8'hFF;
  end

  generate
    if (EXT_MODE) begin : g_ext
      assign upper_zone = (wr_addr >= 16'hC000);
      assign mir_match  = (masked == 16'hE000);
    end else begin : g_base
      assign upper_zone = 1'b0;
      assign mir_match  = 1'b0;
    end
  endgenerate

  assign bank_wr = wr_en && !upper_zone && bank_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs   <= '0;
      mirror <= MIR_VERT;
      hit    <= 1'b0;
    end else begin
      hit <= bank_wr || (wr_en && mir_match);
      if (bank_wr) begin
        regs[idx] <= wr_data & keep;
      end
      if (bank_wr && (idx == 3'd0) && R0_MIRRORS) begin
        mirror <= mirror_e'(wr_data[6]);
      end
      if (wr_en && mir_match) begin
        mirror <= mirror_e'(wr_data[6]);
      end
    end
  end

endmodule

// File: rtl/cbx_prg_xlat.sv
module cbx_prg_xlat
  import cbx_pkg::*;
#(
  parameter int BANKS = 16,
  parameter int AW    = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   rd_addr,
  input  logic [7:0]    bank_a,
  input  logic [7:0]    bank_b,
  output logic [AW-1:0] rom_addr,
  output logic          sel
);

  localparam int BW     = AW - 13;
  localparam int FIX_LO = (BANKS >= 2) ? BANKS - 2 : 0;
  localparam int FIX_HI = (BANKS >= 1) ? BANKS - 1 : 0;

  logic [7:0]    sw_reg [2];
  logic [BW-1:0] slot_bank [4];
  logic [AW-1:0] next_addr;

  assign sw_reg[0] = bank_a;
  assign sw_reg[1] = bank_b;

  genvar w;
  generate
    for (w = 0; w < 4; w++) begin : g_slot
      if (w < 2) begin : g_switch
        assign slot_bank[w] = BW'(wrap_bank(sw_reg[w], BANKS));
      end else begin : g_fixed
        assign slot_bank[w] = BW'((w == 2) ? FIX_LO : FIX_HI);
      end
    end
  endgenerate

  assign next_addr = {slot_bank[rd_addr[14:13]], rd_addr[12:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      sel      <= 1'b0;
    end else begin
      sel      <= rd_addr[15];
      rom_addr <= rd_addr[15] ? next_addr : '0;
    end
  end

endmodule

// File: rtl/cbx_chr_xlat.sv
module cbx_chr_xlat
  import cbx_pkg::*;
#(
  parameter int BANKS1K = 128,
  parameter int AW      = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [13:0]   vid_addr,
  input  bank_file_t    regs,
  output logic [AW-1:0] rom_addr,
  output logic          sel
);

  localparam int BANKS2K = (BANKS1K / 2 < 1) ? 1 : BANKS1K / 2;

  logic [AW-1:0] slot_base [8];
  logic [AW-1:0] next_addr;
  logic          in_win;

  genvar s;
  generate
    for (s = 0; s < 8; s++) begin : g_slot
      if (s < 4) begin : g_wide
        assign slot_base[s] = AW'(wrap_bank(regs[2 + s / 2], BANKS2K) * CHR_PAGE2
                                  + (s % 2) * CHR_PAGE1);
      end else begin : g_narrow
        assign slot_base[s] = AW'(wrap_bank(regs[s], BANKS1K) * CHR_PAGE1);
      end
    end
  endgenerate

  assign in_win    = !vid_addr[13];
  assign next_addr = slot_base[vid_addr[12:10]] | AW'(vid_addr[9:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      sel      <= 1'b0;
    end else begin
      sel      <= in_win;
      rom_addr <= in_win ? next_addr : '0;
    end
  end

endmodule

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat
  import cbx_pkg::*;
#(
  parameter int PRG_BANKS8  = 16,
  parameter int CHR_BANKS1K = 128,
  parameter bit EXT_MODE    = 1'b0,
  localparam int PRG_AW     = $clog2(PRG_BANKS8) + 13,
  localparam int CHR_AW     = $clog2(CHR_BANKS1K) + 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic [15:0]       cpu_wr_addr,
  input  logic [7:0]        cpu_wr_data,
  output logic              cpu_wr_hit,
  input  logic [15:0]       cpu_rd_addr,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic              prg_sel,
  input  logic [13:0]       vid_addr,
  output logic [CHR_AW-1:0] chr_rom_addr,
  output logic              chr_sel,
  output logic              mirror_h
);

  bank_file_t regs;
  mirror_e    mirror;

  cbx_regfile #(.EXT_MODE(EXT_MODE)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_wr_en),
    .wr_addr (cpu_wr_addr),
    .wr_data (cpu_wr_data),
    .regs    (regs),
    .mirror  (mirror),
    .hit     (cpu_wr_hit)
  );

  cbx_prg_xlat #(.BANKS(PRG_BANKS8), .AW(PRG_AW)) u_prg (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (cpu_rd_addr),
    .bank_a   (regs[0]),
    .bank_b   (regs[1]),
    .rom_addr (prg_rom_addr),
    .sel      (prg_sel)
  );

  cbx_chr_xlat #(.BANKS1K(CHR_BANKS1K), .AW(CHR_AW)) u_chr (
    .clk      (clk),
    .rst      (rst),
    .vid_addr (vid_addr),
    .regs     (regs),
    .rom_addr (chr_rom_addr),
    .sel      (chr_sel)
  );

  assign mirror_h = (mirror == MIR_HORZ);

endmodule

// File: rtl/cbx_chk.sv
module cbx_chk #(
  parameter int PRG_BANKS8 = 16,
  parameter int PRG_AW     = 17,
  parameter int CHR_AW     = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr_en,
  input logic              cpu_wr_hit,
  input logic [15:0]       cpu_rd_addr,
  input logic [PRG_AW-1:0] prg_rom_addr,
  input logic              prg_sel,
  input logic [13:0]       vid_addr,
  input logic [CHR_AW-1:0] chr_rom_addr,
  input logic              chr_sel,
  input logic              mirror_h
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!mirror_h && !cpu_wr_hit && !prg_sel && !chr_sel));

  // R11
  hit_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_hit |-> $past(cpu_wr_en));

  // R8
  mirror_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_wr_en) |-> $stable(mirror_h));

  // R5
  fixed_last_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_addr[15:13] == 3'b111) |=>
      (prg_rom_addr[PRG_AW-1:13] == (PRG_AW-13)'(PRG_BANKS8 - 1)) &&
      (prg_rom_addr[12:0] == $past(cpu_rd_addr[12:0])));

  // R5
  fixed_next_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_addr[15:13] == 3'b110) |=>
      (prg_rom_addr[PRG_AW-1:13] == (PRG_AW-13)'(PRG_BANKS8 - 2)) &&
      (prg_rom_addr[12:0] == $past(cpu_rd_addr[12:0])));

  // R13
  prg_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd_addr[15] |=> (!prg_sel && (prg_rom_addr == '0)));

  // R7
  chr_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (vid_addr[13:12] == 2'b01) |=>
      (chr_sel && (chr_rom_addr[9:0] == $past(vid_addr[9:0]))));

endmodule

bind cart_bank_xlat cbx_chk #(
  .PRG_BANKS8 (PRG_BANKS8),
  .PRG_AW     (PRG_AW),
  .CHR_AW     (CHR_AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_wr_en    (cpu_wr_en),
  .cpu_wr_hit   (cpu_wr_hit),
  .cpu_rd_addr  (cpu_rd_addr),
  .prg_rom_addr (prg_rom_addr),
  .prg_sel      (prg_sel),
  .vid_addr     (vid_addr),
  .chr_rom_addr (chr_rom_addr),
  .chr_sel      (chr_sel),
  .mirror_h     (mirror_h)
);

// File: tb/tb_cart_bank_xlat.sv
module tb_cart_bank_xlat;

  localparam int CLK_PERIOD = 10;
  localparam int PB0 = 16, CB0 = 128;
  localparam int PB1 = 12, CB1 = 40;
  localparam int PAW0 = $clog2(PB0) + 13, CAW0 = $clog2(CB0) + 10;
  localparam int PAW1 = $clog2(PB1) + 13, CAW1 = $clog2(CB1) + 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [13:0] v_addr = '0;

  logic            hit0, psel0, csel0, mir0;
  logic [PAW0-1:0] prg0;
  logic [CAW0-1:0] chr0;
  logic            hit1, psel1, csel1, mir1;
  logic [PAW1-1:0] prg1;
  logic [CAW1-1:0] chr1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cart_bank_xlat #(.PRG_BANKS8(PB0), .CHR_BANKS1K(CB0), .EXT_MODE(1'b0)) dut (
    .clk(clk), .rst(rst), .cpu_wr_en(wr_en), .cpu_wr_addr(wr_addr),
    .cpu_wr_data(wr_data), .cpu_wr_hit(hit0), .cpu_rd_addr(rd_addr),
    .prg_rom_addr(prg0), .prg_sel(psel0), .vid_addr(v_addr),
    .chr_rom_addr(chr0), .chr_sel(csel0), .mirror_h(mir0));

  cart_bank_xlat #(.PRG_BANKS8(PB1), .CHR_BANKS1K(CB1), .EXT_MODE(1'b1)) dut_ext (
    .clk(clk), .rst(rst), .cpu_wr_en(wr_en), .cpu_wr_addr(wr_addr),
    .cpu_wr_data(wr_data), .cpu_wr_hit(hit1), .cpu_rd_addr(rd_addr),
    .prg_rom_addr(prg1), .prg_sel(psel1), .vid_addr(v_addr),
    .chr_rom_addr(chr1), .chr_sel(csel1), .mirror_h(mir1));

  // behavioural reference: [variant][register]
  int    m_reg [2][8];
  int    m_mir [2];
  int    e_prg [2], e_chr [2], e_hit [2], e_psel [2], e_csel [2];
  bit    armed = 1'b0;
  bit    done = 1'b0;
  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";

  function automatic int pcount(int v); return (v == 0) ? PB0 : PB1; endfunction
  function automatic int ccount(int v); return (v == 0) ? CB0 : CB1; endfunction

  function automatic int model_prg(int v, int ra);
    int slot, bank;
    if (ra < 32768) return 0;
    slot = (ra >> 13) & 3;
    case (slot)
      0: bank = m_reg[v][0] % pcount(v);
      1: bank = m_reg[v][1] % pcount(v);
      2: bank = pcount(v) - 2;
      default: bank = pcount(v) - 1;
    endcase
    return bank * 8192 + (ra % 8192);
  endfunction

  function automatic int model_chr(int v, int va);
    int r;
    if (va >= 8192) return 0;
    if (va < 4096) begin
      r = (va < 2048) ? m_reg[v][2] : m_reg[v][3];
      return (r % (ccount(v) / 2)) * 2048 + (va % 2048);
    end
    r = m_reg[v][4 + ((va >> 10) & 3)];
    return (r % ccount(v)) * 1024 + (va % 1024);
  endfunction

  function automatic int model_write(int v, int a, int d);
    int m, top, idx;
    m = a & 'hF003;
    top = m >> 12;
    if (v == 1 && a >= 'hC000) begin
      if (m == 'hE000) begin
        m_mir[v] = (d >> 6) & 1;
        return 1;
      end
      return 0;
    end
    if ((top != 8 && top != 10) || (m & 'h0FFC) != 0) return 0;
    idx = ((top == 10) ? 4 : 0) + (m & 3);
    m_reg[v][idx] = (idx < 2) ? (d & 'h3F) : d;
    if (idx == 0 && v == 0) m_mir[v] = (d >> 6) & 1;
    return 1;
  endfunction

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (rst) begin
        for (int i = 0; i < 8; i++) m_reg[v][i] = 0;
        m_mir[v] = 0; e_prg[v] = 0; e_chr[v] = 0; e_hit[v] = 0;
        e_psel[v] = 0; e_csel[v] = 0;
      end else begin
        e_prg[v]  = model_prg(v, int'(rd_addr));
        e_chr[v]  = model_chr(v, int'(v_addr));
        e_psel[v] = (rd_addr >= 16'h8000) ? 1 : 0;
        e_csel[v] = (v_addr < 14'h2000) ? 1 : 0;
        e_hit[v]  = wr_en ? model_write(v, int'(wr_addr), int'(wr_data)) : 0;
      end
    end
    armed = 1'b1;
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("base prg_rom_addr", int'(prg0), e_prg[0]);
      chk("base chr_rom_addr", int'(chr0), e_chr[0]);
      chk("base cpu_wr_hit", int'(hit0), e_hit[0]);
      chk("base prg_sel", int'(psel0), e_psel[0]);
      chk("base chr_sel", int'(csel0), e_csel[0]);
      chk("base mirror_h", int'(mir0), m_mir[0]);
      chk("ext prg_rom_addr", int'(prg1), e_prg[1]);
      chk("ext chr_rom_addr", int'(chr1), e_chr[1]);
      chk("ext cpu_wr_hit", int'(hit1), e_hit[1]);
      chk("ext prg_sel", int'(psel1), e_psel[1]);
      chk("ext chr_sel", int'(csel1), e_csel[1]);
      chk("ext mirror_h", int'(mir1), m_mir[1]);
    end
  end

  task automatic cyc(bit we, int wa, int wd, int ra, int va);
    @(negedge clk);
    wr_en   = we;
    wr_addr = 16'(wa);
    wr_data = 8'(wd);
    rd_addr = 16'(ra);
    v_addr  = 14'(va);
  endtask

  task automatic wr(int wa, int wd);
    cyc(1'b1, wa, wd, 0, 'h3FFF);
  endtask

  task automatic sweep_prg();
    for (int s = 0; s < 4; s++) begin
      cyc(1'b0, 0, 0, 'h8000 + s * 'h2000, 'h3000);
      cyc(1'b0, 0, 0, 'h9FFF + s * 'h2000, 'h3000);
      cyc(1'b0, 0, 0, 'h8A5C + s * 'h2000, 'h3000);
    end
  endtask

  task automatic sweep_chr();
    for (int s = 0; s < 8; s++) begin
      cyc(1'b0, 0, 0, 0, s * 'h400);
      cyc(1'b0, 0, 0, 0, s * 'h400 + 'h3FF);
      cyc(1'b0, 0, 0, 0, s * 'h400 + 'h1A7);
    end
  endtask

  initial begin
    // R1: reset state observed through the per-cycle compare
    cur_req = "R1";
    repeat (4) cyc(1'b0, 0, 0, 'h8000, 0);
    rst = 1'b0;
    cyc(1'b0, 0, 0, 'h8000, 0);
    cyc(1'b0, 0, 0, 'hA123, 'h1400);
    // R13: selects and zeroed outputs outside the windows
    cur_req = "R13";
    cyc(1'b0, 0, 0, 'h7FFF, 'h2000);
    cyc(1'b0, 0, 0, 'h0000, 'h3FFF);
    // R4: switchable program slots
    cur_req = "R4";
    wr('h8000, 5);
    wr('h8001, 7);
    sweep_prg();
    // R3: low six bits kept in registers 0 and 1; R10 wrap beyond count
    cur_req = "R3 R10";
    wr('h8000, 'hBF);
    wr('h8001, 'hFF);
    sweep_prg();
    // R5: fixed upper slots unaffected by registers
    cur_req = "R5";
    wr('h8000, 'h3E);
    cyc(1'b0, 0, 0, 'hC000, 0);
    cyc(1'b0, 0, 0, 'hDFFF, 0);
    cyc(1'b0, 0, 0, 'hE000, 0);
    cyc(1'b0, 0, 0, 'hFFFF, 0);
    // R6 R7: pattern slots
    cur_req = "R6 R7";
    wr('h8002, 3);  wr('h8003, 9);
    wr('hA000, 1);  wr('hA001, 2);  wr('hA002, 30); wr('hA003, 39);
    sweep_chr();
    // R10: full-width pattern banks wrap
    cur_req = "R10";
    wr('h8002, 'hFF); wr('h8003, 'h41); wr('hA000, 'hC8); wr('hA003, 'h80);
    sweep_chr();
    // R2: masked aliases and near-miss addresses
    cur_req = "R2";
    wr('h8FFC, 11);
    wr('hAFF3, 17);
    wr('h9000, 'h22);
    wr('hB001, 'h23);
    wr('h8004, 'h24);
    sweep_prg();
    sweep_chr();
    // R8: base variant mirroring from register 0 bit 6
    cur_req = "R8";
    wr('h8000, 'h40);
    cyc(1'b0, 0, 0, 'h8000, 0);
    wr('h8000, 'h01);
    cyc(1'b0, 0, 0, 'h8000, 0);
    wr('h8000, 'h44);
    // R9: extended variant mirroring register and upper-zone isolation
    cur_req = "R9";
    wr('hE000, 'h40);
    cyc(1'b0, 0, 0, 'hE000, 0);
    wr('hEFFC, 'h00);
    wr('hE000, 'h7F);
    wr('hC000, 'h12);
    wr('hC002, 'h34);
    wr('hE001, 'h56);
    wr('hE003, 'hFF);
    sweep_prg();
    // R11: strobe-free cycles with write fields set are ignored
    cur_req = "R11";
    cyc(1'b0, 'h8000, 'h3F, 'h8000, 0);
    cyc(1'b0, 'hE000, 'h00, 'h8000, 0);
    cyc(1'b0, 'hA003, 'h77, 0, 'h1C00);
    // R12: write and read of the same slot in the same cycle
    cur_req = "R12";
    cyc(1'b1, 'h8001, 9, 'hA010, 'h1C10);
    cyc(1'b1, 'hA003, 5, 'hA010, 'h1C10);
    cyc(1'b0, 0, 0, 'hA010, 'h1C10);
    cyc(1'b0, 0, 0, 'hA010, 'h1C10);
    // R2 R4 R6 R7 R9 R11: mixed random traffic
    cur_req = "R2 R4 R6 R7 R9 R11 random";
    for (int n = 0; n < 1500; n++) begin
      int a, pick;
      pick = int'($urandom_range(0, 5));
      case (pick)
        0: a = 'h8000 | int'($urandom_range(0, 'h1FFF));
        1: a = 'hA000 | int'($urandom_range(0, 'h1FFF));
        2: a = 'hC000 | int'($urandom_range(0, 'h1FFF));
        3: a = 'hE000 | (int'($urandom_range(0, 'h1FFF)) & 'h0FFC);
        4: a = 'h8000 | (int'($urandom_range(0, 'h7FFF)) & 'h2003);
        default: a = int'($urandom_range(0, 'hFFFF));
      endcase
      cyc(1'($urandom_range(0, 1)), a, int'($urandom_range(0, 255)),
          int'($urandom_range(0, 'hFFFF)), int'($urandom_range(0, 'h3FFF)));
    end
    // R1: reset mid-run returns to the reset state
    cur_req = "R1 mid-run";
    rst = 1'b1;
    cyc(1'b0, 0, 0, 'h8000, 'h1000);
    cyc(1'b0, 0, 0, 'h8000, 'h1000);
    rst = 1'b0;
    cyc(1'b0, 0, 0, 'hA000, 'h1000);
    cyc(1'b0, 0, 0, 'hA000, 'h1000);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule